// File: doc/BRIEF.md
# Tracking Converter Step Controller

This block is the digital half of a servo-style analog-to-digital converter. It holds a code that feeds an external DAC, and it reads a single comparator bit that says whether the DAC's test level is above the analog input. On every enabled step the code moves one count toward the input. After a reset it climbs from zero until the test level first passes the input. From then on it follows the input continuously. With a steady input it toggles by one count around the input level. After a large change in the input it ramps toward the new level.

The step rate comes from an internal clock-enable divider. The comparator bit comes from the analog domain, so it passes through a two-flop synchronizer first. Two status flags are derived from the history of step directions. One flag reports lock, meaning the code is dithering around the input. The other reports slewing, meaning the code is running in one direction after an input jump. The code saturates at both ends of its range instead of wrapping.

Top module: `trk_adc_ctrl`

## Requirements
- R1: The code changes only on a step, and a step happens once every `STEP_DIV` clocks. On a step where the synchronized comparator is high (test level above input), the code drops by one. Otherwise it rises by one.
- R2: After reset the block is in a catch-up phase. In this phase the code only climbs and `locked_o` and `slewing_o` stay 0, however long the climb lasts. The first step that sees the comparator high moves the code down and starts tracking.
- R3: The code saturates. A down step at code 0 leaves it at 0, and an up step at code 255 leaves it at 255. The code never wraps around.
- R4: With a constant input v, the comparator is high when code > v. Under this input the code settles to alternate between v and v+1.
- R5: `locked_o` goes to 1 on a tracking step that is the second direction reversal in a row.
- R6: `locked_o` clears and `slewing_o` goes to 1 when, during tracking, the run of moves in one direction reaches `SLEW_RUN`. `slewing_o` clears on the next reversal.
- R7: The comparator input is sampled through two flip-flops. Each step acts on the value the comparator had two clocks before that step's edge.
- R8: A low `rst_n` that is sampled on a clock edge returns the code to 0, clears both flags and re-enters catch-up, even in the middle of operation.
- R9: `locked_o` and `slewing_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_above_i | input | 1 | Comparator bit, asynchronous: 1 when the DAC test level is above the analog input |
| code_o | output | CODE_W (8) | Current DAC code |
| locked_o | output | 1 | Code is dithering around the input |
| slewing_o | output | 1 | Code is ramping in one direction after an input jump |

## Verification
The bench uses the defaults `CODE_W` = 8, `STEP_DIV` = 4, `SLEW_RUN` = 4 and `SYNC_STAGES` = 2. A divider of 4 lets the synchronized comparator settle between steps. It also keeps a full-scale ramp under about a thousand clocks, so both saturation ends, a full catch-up and many input jumps fit into one run. A slewing threshold of 4 is short enough that jumps of a few counts already toggle lock and slewing. The random segments therefore cover the transitions between the flags as well as the steady dither.

// File: rtl/trk_pkg.sv
// Shared types for the tracking converter controller.
// Assumes nothing beyond the 1800-2017 language.
package trk_pkg;
    typedef enum logic {
        PH_CATCHUP = 1'b0,
        PH_TRACK   = 1'b1
    } trk_phase_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } trk_dir_e;
endpackage

// File: rtl/trk_sync.sv
// Multi-stage flip-flop synchronizer for a single asynchronous bit.
// Assumes STAGES >= 2 and that the input is a level, not a pulse.
module trk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            // one flop of the chain, stage 0 samples the raw input
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain[gi] <= 1'b0;
                else if (gi == 0)
                    chain[gi] <= d_i;
                else
                    chain[gi] <= chain[(gi == 0) ? 0 : gi-1];
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/trk_prescale.sv
// Clock-enable divider: step_o is high for one clock in every DIV clocks.
// Assumes DIV >= 1. The first pulse is in the DIV-th cycle after reset.
module trk_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic step_o
);
    generate
        if (DIV <= 1) begin : g_every
            assign step_o = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt;

            assign step_o = (cnt == LAST);

            // free-running modulo-DIV counter
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cnt <= '0;
                else if (step_o)
                    cnt <= '0;
                else
                    cnt <= cnt + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/trk_updown.sv
// Saturating up/down code register with the catch-up/track phase.
// Assumes above_i is already synchronized. On a step it moves toward the
// input. move_o flags a step that really changed the code.
module trk_updown
    import trk_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              above_i,
    output logic [CODE_W-1:0] code_o,
    output logic              move_o,
    output trk_dir_e          dir_o,
    output logic              track_o,
    output logic              catchup_o
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    trk_phase_e phase;
    logic       at_top;
    logic       at_bottom;

    // direction and saturation decode for the current step
    always_comb begin
        at_top    = (code_o == CODE_MAX);
        at_bottom = (code_o == '0);
        dir_o     = above_i ? DIR_DOWN : DIR_UP;
        move_o    = step_i && (above_i ? !at_bottom : !at_top);
        track_o   = (phase == PH_TRACK) || (step_i && above_i);
        catchup_o = (phase == PH_CATCHUP);
    end

    // code register and phase update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o <= '0;
            phase  <= PH_CATCHUP;
        end else begin
            if (step_i && above_i)
                phase <= PH_TRACK;
            if (move_o) begin
                if (dir_o == DIR_DOWN)
                    code_o <= code_o - 1'b1;
                else
                    code_o <= code_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/trk_lock.sv
// Lock and slew detector based on the direction history of real moves.
// Assumes SLEW_RUN >= 2. Two reversals in a row set lock. A same-direction
// run of SLEW_RUN moves clears lock and flags slewing. Flags change only in
// the tracking phase.
module trk_lock
    import trk_pkg::*;
#(
    parameter int SLEW_RUN = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     move_i,
    input  trk_dir_e dir_i,
    input  logic     track_i,
    output logic     locked_o,
    output logic     slewing_o
);
    localparam int RW = $clog2(SLEW_RUN + 1);
    localparam logic [RW-1:0] RUN_LIM = RW'(SLEW_RUN);
    localparam logic [RW-1:0] RUN_ONE = RW'(1);

    trk_dir_e      prev_dir;
    logic [1:0]    rev_cnt;
    logic [1:0]    rev_nxt;
    logic [RW-1:0] run_cnt;
    logic [RW-1:0] run_nxt;
    logic          reversal;

    // next reversal streak and run length
    always_comb begin
        reversal = (dir_i != prev_dir);
        if (reversal) begin
            rev_nxt = (rev_cnt == 2'd2) ? 2'd2 : rev_cnt + 2'd1;
            run_nxt = RUN_ONE;
        end else begin
            rev_nxt = 2'd0;
            run_nxt = (run_cnt == RUN_LIM) ? RUN_LIM : run_cnt + RUN_ONE;
        end
    end

    // history registers and status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_dir  <= DIR_UP;
            rev_cnt   <= 2'd0;
            run_cnt   <= '0;
            locked_o  <= 1'b0;
            slewing_o <= 1'b0;
        end else if (move_i) begin
            prev_dir <= dir_i;
            rev_cnt  <= rev_nxt;
            run_cnt  <= run_nxt;
            if (track_i) begin
                if (run_nxt == RUN_LIM) begin
                    locked_o  <= 1'b0;
                    slewing_o <= 1'b1;
                end else if (rev_nxt == 2'd2) begin
                    locked_o  <= 1'b1;
                    slewing_o <= 1'b0;
                end else if (reversal) begin
                    slewing_o <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/trk_adc_ctrl.sv
// Top of the tracking converter controller: synchronizer, step divider,
// up/down code register and lock/slew detector.
// Assumes STEP_DIV > SYNC_STAGES, so a step always sees the comparator
// response to the previous code, and SLEW_RUN >= 2.
module trk_adc_ctrl
    import trk_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int STEP_DIV    = 4,
    parameter int SLEW_RUN    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_above_i,
    output logic [CODE_W-1:0] code_o,
    output logic              locked_o,
    output logic              slewing_o
);
    logic     above_s;
    logic     step_en;
    logic     move;
    logic     track;
    logic     in_catchup;
    trk_dir_e dir;

    trk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cmp_above_i),
        .q_o   (above_s)
    );

    trk_prescale #(.DIV(STEP_DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_o (step_en)
    );

    trk_updown #(.CODE_W(CODE_W)) u_code (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step_en),
        .above_i   (above_s),
        .code_o    (code_o),
        .move_o    (move),
        .dir_o     (dir),
        .track_o   (track),
        .catchup_o (in_catchup)
    );

    trk_lock #(.SLEW_RUN(SLEW_RUN)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .move_i    (move),
        .dir_i     (dir),
        .track_i   (track),
        .locked_o  (locked_o),
        .slewing_o (slewing_o)
    );
endmodule

// File: rtl/trk_adc_ctrl_chk.sv
// Property checker for trk_adc_ctrl, attached by bind.
// Assumes reset is held for at least two clock edges.
module trk_adc_ctrl_chk #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step_en,
    input logic              in_catchup,
    input logic [CODE_W-1:0] code,
    input logic              locked,
    input logic              slewing
);
    localparam logic [CODE_W-1:0] CMAX = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] CONE = CODE_W'(1);

    assert_hold_between_steps_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(code));

    assert_unit_move_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (code != $past(code)) |-> ((code - $past(code)) == CONE || ($past(code) - code) == CONE));

    assert_no_wrap_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(code) == CMAX) |-> (code != '0));

    assert_no_wrap_bottom_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(code) == '0) |-> (code != CMAX));

    assert_catchup_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_catchup |-> (!locked && !slewing));

    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked && slewing));
endmodule

bind trk_adc_ctrl trk_adc_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_en    (step_en),
    .in_catchup (in_catchup),
    .code       (code_o),
    .locked     (locked_o),
    .slewing    (slewing_o)
);

// File: tb/trk_adc_ctrl_tb.sv
// Bench for trk_adc_ctrl: models the DAC and comparator, keeps a step-level
// reference of the requirements, and mixes directed and random input levels.
module trk_adc_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CODE_W     = 8;
    localparam int STEP_DIV   = 4;
    localparam int SLEW_RUN   = 4;
    localparam int CMAX       = (1 << CODE_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    int                vin = 100;
    logic              cmp;
    logic [CODE_W-1:0] code_o;
    logic              locked_o;
    logic              slewing_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // comparator model: test level above input when code > vin (R4)
    assign cmp = (int'(code_o) > vin);

    trk_adc_ctrl #(
        .CODE_W(CODE_W), .STEP_DIV(STEP_DIV), .SLEW_RUN(SLEW_RUN), .SYNC_STAGES(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cmp_above_i(cmp),
        .code_o(code_o), .locked_o(locked_o), .slewing_o(slewing_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // reference state, kept at step granularity from the requirements
    int m_code, m_pcnt, m_rev, m_run;
    bit m_s1, m_s2, m_track, m_prev_dn, m_locked, m_slew;

    function automatic int nxt_rev(int r, bit rv);
        return rv ? ((r >= 2) ? 2 : r + 1) : 0;
    endfunction

    function automatic int nxt_run(int r, bit rv);
        return rv ? 1 : ((r >= SLEW_RUN) ? SLEW_RUN : r + 1);
    endfunction

    always @(posedge clk) begin : ref_model
        bit tick, dn, mv, rv, trk;
        int rn, un;
        if (!rst_n) begin
            m_code <= 0; m_pcnt <= 0; m_rev <= 0; m_run <= 0;
            m_s1 <= 0; m_s2 <= 0; m_track <= 0; m_prev_dn <= 0;
            m_locked <= 0; m_slew <= 0;
        end else begin
            m_s1 <= cmp;                       // R7 two-stage sampling
            m_s2 <= m_s1;
            tick = (m_pcnt == STEP_DIV - 1);
            m_pcnt <= tick ? 0 : m_pcnt + 1;
            if (tick) begin
                dn  = m_s2;
                mv  = dn ? (m_code > 0) : (m_code < CMAX);   // R3
                trk = m_track || dn;                          // R2
                if (dn) m_track <= 1;
                if (mv) begin
                    m_code <= dn ? m_code - 1 : m_code + 1;   // R1
                    rv = (dn != m_prev_dn);
                    rn = nxt_rev(m_rev, rv);
                    un = nxt_run(m_run, rv);
                    m_prev_dn <= dn;
                    m_rev <= rn;
                    m_run <= un;
                    if (trk) begin
                        if (un == SLEW_RUN) begin m_locked <= 0; m_slew <= 1; end // R6
                        else if (rn == 2) begin m_locked <= 1; m_slew <= 0; end  // R5
                        else if (rv) m_slew <= 0;
                    end
                end
            end
        end
    end

    // continuous comparison against the reference, away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(int'(code_o) == m_code, "R1/R7 code", int'(code_o), m_code);
            check(locked_o == m_locked, "R5 locked", int'(locked_o), int'(m_locked));
            check(slewing_o == m_slew, "R6 slewing", int'(slewing_o), int'(m_slew));
            check(!(locked_o && slewing_o), "R9 exclusive", int'(locked_o && slewing_o), 0);
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        vin = 100;
        wait_cyc(3);
        // R8 reset state
        check(code_o == '0, "R8 reset code", int'(code_o), 0);
        check(!locked_o && !slewing_o, "R8 reset flags", int'(locked_o) + int'(slewing_o), 0);
        rst_n = 1'b1;

        // R2 mid catch-up: climbing, flags quiet
        wait_cyc(40 * STEP_DIV);
        check(code_o > 0 && int'(code_o) < vin, "R2 climbing", int'(code_o), 40);
        check(!locked_o && !slewing_o, "R2 flags quiet", int'(locked_o) + int'(slewing_o), 0);

        // R4/R5 constant input settles and locks
        wait_cyc(2000);
        check(int'(code_o) == vin || int'(code_o) == vin + 1, "R4 dither", int'(code_o), vin);
        check(locked_o == 1'b1, "R5 locked", int'(locked_o), 1);

        // R6 jump up: slewing, then locked at the new level
        vin = 180;
        wait_cyc(20 * STEP_DIV);
        check(slewing_o == 1'b1 && locked_o == 1'b0, "R6 slewing up", int'(slewing_o), 1);
        wait_cyc(600);
        check(int'(code_o) == 180 || int'(code_o) == 181, "R4 new level", int'(code_o), 180);
        check(slewing_o == 1'b0 && locked_o == 1'b1, "R6 slew cleared", int'(slewing_o), 0);

        // R3 bottom saturation (input below zero)
        vin = -1;
        wait_cyc(1200);
        check(code_o == '0, "R3 floor", int'(code_o), 0);
        wait_cyc(100);
        check(code_o == '0, "R3 floor held", int'(code_o), 0);

        // R3 top saturation
        vin = CMAX;
        wait_cyc(1400);
        check(int'(code_o) == CMAX, "R3 ceiling", int'(code_o), CMAX);
        wait_cyc(100);
        check(int'(code_o) == CMAX, "R3 ceiling held", int'(code_o), CMAX);

        // R8 reset in the middle of operation
        rst_n = 1'b0;
        wait_cyc(3);
        check(code_o == '0, "R8 mid reset code", int'(code_o), 0);
        check(!locked_o && !slewing_o, "R8 mid reset flags", int'(locked_o) + int'(slewing_o), 0);
        vin = 60;
        rst_n = 1'b1;
        wait_cyc(30 * STEP_DIV);
        check(!locked_o && !slewing_o, "R2 catch-up again", int'(locked_o) + int'(slewing_o), 0);
        wait_cyc(400);
        check(int'(code_o) == 60 || int'(code_o) == 61, "R4 after reset", int'(code_o), 60);

        // random input levels: full-range jumps and small nudges
        for (int seg = 0; seg < 40; seg++) begin
            if ($urandom_range(0, 2) == 0)
                vin = $urandom_range(0, CMAX);
            else begin
                vin = vin + $urandom_range(0, 6) - 3;
                if (vin < -1) vin = -1;
                if (vin > CMAX) vin = CMAX;
            end
            wait_cyc($urandom_range(30, 1300));
        end
        finish_run();
    end
endmodule